// File: doc/BRIEF.md
# Line Frame Builder with Scrambling and Reed-Solomon Protection

This block assembles one 120-bit line frame per frame strobe, which in the system arrives once per 25 ns bunch-crossing period and so sets a 4.8 Gb/s line rate. Each frame starts with a 4-bit header that marks the frame as carrying data or as idle. An 84-bit payload follows. It holds four slow-control bits and an 80-bit user word. A 32-bit low field closes the frame. A downstream serializer sends the finished word.

There are three ways to fill a frame. In the protected mode the payload passes through a self-synchronizing multiplicative scrambler, which keeps the line DC-balanced. After scrambling, the header and scrambled payload are split into two interleaved Reed-Solomon (15,11) codewords over 4-bit symbols, and the 32-bit low field carries their parity. In the wide mode there is no parity. The low field instead carries 32 more user bits, scrambled by a second, independent scrambler, so each frame holds 112 data bits. In the raw mode, used for a line code that is already DC-balanced, nothing is scrambled and nothing is protected.

Top module: `fb_frame_builder`

## Requirements
- R1: While `rstN` is low, `frameOut` is all zeros and `frameValid` is low.
- R2: A cycle with `frameStb` high loads a new frame, which appears on `frameOut` after the next rising clock edge, and `frameValid` is high for exactly that one cycle. A cycle with `frameStb` low leaves `frameOut` unchanged and `frameValid` low.
- R3: The header `frameOut[119:116]` is 4'b0101 when `dataValid` was high at the strobe and 4'b0110 when it was low.
- R4: In protected mode (`mode`=0) the payload is `frameOut[115:32]`. It is the scrambled image of {`scBits`, `userData`}, with `scBits` in the top four bits. Scrambled bit i (i=0 is frame bit 32, taken first) is the input bit XOR the scrambled bits 39 and 58 positions earlier. This history carries across frames and is all ones after reset.
- R5: In protected mode, the frame nibble at bits [4n+3:4n] is symbol n/2 of codeword A when n is even and symbol (n-1)/2 of codeword B when n is odd. Symbol t is the coefficient of x^t, and symbols 0 to 3 are parity. Each codeword evaluates to zero at alpha^1 to alpha^4 in GF(16), where alpha is a root of x^4+x+1.
- R6: In wide mode (`mode`=1) the payload is scrambled as in R4. `frameOut[31:0]` is `wideData` scrambled by a second scrambler. Its bit i (i=0 is frame bit 0, taken first) is the input bit XOR the scrambled bits 28 and 31 positions earlier. Its history is all ones after reset.
- R7: In raw mode (`mode`=2) `frameOut[115:0]` equals {`scBits`, `userData`, `wideData`} unchanged, and neither scrambler history moves.
- R8: The payload scrambler history moves only on protected and wide frames. The wide scrambler history moves only on wide frames.
- R9: `mode`=3 builds the same frame as protected mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| frameStb | input | 1 | Build a frame from the inputs of this cycle |
| dataValid | input | 1 | 1: data frame header, 0: idle frame header |
| mode | input | 2 | 0 protected, 1 wide, 2 raw, 3 protected |
| userData | input | 80 | User data word |
| scBits | input | 4 | Slow-control bits |
| wideData | input | 32 | Extra data for the low field in wide and raw modes |
| frameOut | output | 120 | Last frame built |
| frameValid | output | 1 | High for one cycle when a new frame is on `frameOut` |

## Verification
The bench starts with directed frames. All-zero and all-ones payloads show whether the scrambler seed and feedback taps are right, because with a zero payload the output is nothing but feedback. Runs of random frames then mix all four modes, both headers, back-to-back strobes and gap cycles. A raw or protected frame placed between wide frames shows whether each scrambler history moves only in the modes it belongs to. Parity is never recomputed the same way as the encoder. Instead the bench evaluates both interleaved codewords at the four code roots using log tables, which separates a wrong generator or a wrong symbol interleaving from a correct one.

// File: rtl/fb_pkg.sv
package fb_pkg;

  localparam int SYM_W   = 4;
  localparam int RS_K    = 11;
  localparam int RS_PAR  = 4;
  localparam int MSG_W   = RS_K * SYM_W;
  localparam int PAR_W   = RS_PAR * SYM_W;
  localparam int N_CODES = 2;

  localparam logic [3:0] HDR_DATA = 4'b0101;
  localparam logic [3:0] HDR_IDLE = 4'b0110;

  typedef enum logic [1:0] {
    MODE_PROT = 2'd0,
    MODE_WIDE = 2'd1,
    MODE_RAW  = 2'd2,
    MODE_ALT  = 2'd3
  } fb_mode_e;

  typedef struct packed {
    logic load;
    logic advMain;
    logic advWide;
    logic scrOn;
    logic fecOn;
    logic wideOn;
    logic idle;
  } fb_ctrl_t;

  // GF(16) multiply, field polynomial x^4 + x + 1
  function automatic logic [3:0] gfMul(input logic [3:0] a, input logic [3:0] b);
    logic [3:0] acc;
    logic [3:0] sh;
    acc = '0;
    sh  = a;
    for (int i = 0; i < 4; i++) begin
      if (b[i]) acc = acc ^ sh;
      sh = {sh[2:0], 1'b0} ^ (sh[3] ? 4'h3 : 4'h0);
    end
    return acc;
  endfunction

  // Low coefficients of the monic generator prod (x + alpha^r), r = 1..RS_PAR
  function automatic logic [PAR_W-1:0] rsGenPoly();
    logic [PAR_W+SYM_W-1:0] g;
    logic [PAR_W+SYM_W-1:0] ng;
    logic [3:0] root;
    logic [3:0] hi;
    g    = '0;
    g[3:0] = 4'h1;
    root = 4'h1;
    for (int r = 1; r <= RS_PAR; r++) begin
      root = gfMul(root, 4'h2);
      for (int k = RS_PAR; k >= 0; k--) begin
        hi = (k > 0) ? g[4*(k-1) +: 4] : 4'h0;
        ng[4*k +: 4] = hi ^ gfMul(root, g[4*k +: 4]);
      end
      g = ng;
    end
    return g[PAR_W-1:0];
  endfunction

endpackage

// File: rtl/fb_scrambler.sv
module fb_scrambler #(
  parameter int WIDTH = 84,
  parameter int LONG_TAP = 58,
  parameter int SHORT_TAP = 39,
  parameter logic [LONG_TAP-1:0] SEED = '1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             advance,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  localparam int EXT_W = LONG_TAP + WIDTH;

  logic [LONG_TAP-1:0] state;
  logic [EXT_W-1:0]    ext;

  // ext[LONG_TAP-1:0] is the history (top index most recent), the rest the new bits
  function automatic logic [EXT_W-1:0] runScr(input logic [LONG_TAP-1:0] hist,
                                              input logic [WIDTH-1:0] bits);
    logic [EXT_W-1:0] e;
    e = '0;
    e[LONG_TAP-1:0] = hist;
    for (int i = 0; i < WIDTH; i++) begin
      e[LONG_TAP+i] = bits[i] ^ e[LONG_TAP+i-SHORT_TAP] ^ e[i];
    end
    return e;
  endfunction

  always_comb begin
    ext  = runScr(state, din);
    dout = ext[EXT_W-1:LONG_TAP];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= SEED;
    end else if (advance) begin
      state <= ext[EXT_W-1:WIDTH];
    end
  end

  AST_HIST_FROZEN: assert property (@(posedge clk) disable iff (!rstN)
    !advance |=> $stable(state)) else $error("scrambler history moved"); // R8

endmodule

// File: rtl/fb_rs_enc.sv
module fb_rs_enc
  import fb_pkg::*;
(
  input  logic [MSG_W-1:0] msg,
  output logic [PAR_W-1:0] parity
);

  localparam logic [PAR_W-1:0] GEN = rsGenPoly();

  // Remainder of msg(x) * x^RS_PAR divided by the generator, highest symbol first
  always_comb begin
    logic [PAR_W-1:0] r;
    logic [3:0] fb;
    r = '0;
    for (int j = RS_K - 1; j >= 0; j--) begin
      fb = msg[SYM_W*j +: SYM_W] ^ r[PAR_W-1 -: SYM_W];
      for (int i = RS_PAR - 1; i >= 1; i--) begin
        r[SYM_W*i +: SYM_W] = r[SYM_W*(i-1) +: SYM_W] ^ gfMul(fb, GEN[SYM_W*i +: SYM_W]);
      end
      r[SYM_W-1:0] = gfMul(fb, GEN[SYM_W-1:0]);
    end
    parity = r;
  end

endmodule

// File: rtl/fb_ctrl.sv
module fb_ctrl
  import fb_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       frameStb,
  input  logic       dataValid,
  input  logic [1:0] mode,
  output fb_ctrl_t   ctrl,
  output logic       frameValid
);

  fb_mode_e modeE;

  always_comb begin
    modeE        = fb_mode_e'(mode);
    ctrl.load    = frameStb;
    ctrl.scrOn   = (modeE != MODE_RAW);
    ctrl.fecOn   = (modeE == MODE_PROT) || (modeE == MODE_ALT);
    ctrl.wideOn  = (modeE == MODE_WIDE);
    ctrl.advMain = frameStb && ctrl.scrOn;
    ctrl.advWide = frameStb && ctrl.wideOn;
    ctrl.idle    = !dataValid;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) frameValid <= 1'b0;
    else       frameValid <= frameStb;
  end

  AST_WIDE_ADV_ONLY_WIDE: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.advWide |-> (mode == 2'd1)) else $error("wide history advanced outside wide mode"); // R8

  AST_RAW_NO_ADV: assert property (@(posedge clk) disable iff (!rstN)
    (mode == 2'd2) |-> !ctrl.advMain && !ctrl.advWide) else $error("raw frame advanced a scrambler"); // R7

endmodule

// File: rtl/fb_datapath.sv
module fb_datapath
  import fb_pkg::*;
#(
  parameter int DATA_W = 80,
  parameter int SC_W = 4,
  parameter int WIDE_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  fb_ctrl_t          ctrl,
  input  logic [DATA_W-1:0] userData,
  input  logic [SC_W-1:0]   scBits,
  input  logic [WIDE_W-1:0] wideData,
  output logic [FRAME_W-1:0] frameOut
);

  localparam int PAY_W   = SC_W + DATA_W;
  localparam int PROT_W  = 4 + PAY_W;
  localparam int FRAME_W = PROT_W + WIDE_W;

  logic [PAY_W-1:0]  payRaw;
  logic [PAY_W-1:0]  payScr;
  logic [PAY_W-1:0]  paySel;
  logic [WIDE_W-1:0] wideScr;
  logic [WIDE_W-1:0] lowSel;
  logic [WIDE_W-1:0] fecField;
  logic [3:0]        hdr;
  logic [PROT_W-1:0] protBits;
  logic [N_CODES-1:0][MSG_W-1:0] msgs;
  logic [N_CODES-1:0][PAR_W-1:0] pars;

  assign payRaw = {scBits, userData};

  fb_scrambler #(.WIDTH(PAY_W), .LONG_TAP(58), .SHORT_TAP(39), .SEED('1)) uMainScr (
    .clk(clk), .rstN(rstN), .advance(ctrl.advMain), .din(payRaw), .dout(payScr)
  );

  fb_scrambler #(.WIDTH(WIDE_W), .LONG_TAP(31), .SHORT_TAP(28), .SEED('1)) uWideScr (
    .clk(clk), .rstN(rstN), .advance(ctrl.advWide), .din(wideData), .dout(wideScr)
  );

  always_comb begin
    hdr      = ctrl.idle ? HDR_IDLE : HDR_DATA;
    paySel   = ctrl.scrOn ? payScr : payRaw;
    protBits = {hdr, paySel};
    // even symbols feed code 0, odd symbols code 1
    for (int k = 0; k < RS_K; k++) begin
      msgs[0][SYM_W*k +: SYM_W] = protBits[2*SYM_W*k +: SYM_W];
      msgs[1][SYM_W*k +: SYM_W] = protBits[2*SYM_W*k + SYM_W +: SYM_W];
    end
    for (int i = 0; i < RS_PAR; i++) begin
      fecField[2*SYM_W*i +: SYM_W]         = pars[0][SYM_W*i +: SYM_W];
      fecField[2*SYM_W*i + SYM_W +: SYM_W] = pars[1][SYM_W*i +: SYM_W];
    end
    if (ctrl.fecOn)       lowSel = fecField;
    else if (ctrl.wideOn) lowSel = wideScr;
    else                  lowSel = wideData;
  end

  for (genvar c = 0; c < N_CODES; c++) begin : gCode
    fb_rs_enc uEnc (.msg(msgs[c]), .parity(pars[c]));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          frameOut <= '0;
    else if (ctrl.load) frameOut <= {protBits, lowSel};
  end

  AST_HOLD_NO_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    !ctrl.load |=> $stable(frameOut)) else $error("frame changed without load"); // R2

  AST_HDR_LEGAL: assert property (@(posedge clk) disable iff (!rstN)
    $past(ctrl.load) |-> (frameOut[FRAME_W-1 -: 4] == HDR_DATA) || (frameOut[FRAME_W-1 -: 4] == HDR_IDLE))
    else $error("illegal header"); // R3

endmodule

// File: rtl/fb_frame_builder.sv
module fb_frame_builder
  import fb_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         frameStb,
  input  logic         dataValid,
  input  logic [1:0]   mode,
  input  logic [79:0]  userData,
  input  logic [3:0]   scBits,
  input  logic [31:0]  wideData,
  output logic [119:0] frameOut,
  output logic         frameValid
);

  fb_ctrl_t ctrl;

  fb_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .frameStb(frameStb), .dataValid(dataValid),
    .mode(mode), .ctrl(ctrl), .frameValid(frameValid)
  );

  fb_datapath #(.DATA_W(80), .SC_W(4), .WIDE_W(32)) uData (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .userData(userData),
    .scBits(scBits), .wideData(wideData), .frameOut(frameOut)
  );

  AST_VALID_AFTER_STB: assert property (@(posedge clk) disable iff (!rstN)
    frameStb |=> frameValid) else $error("no valid after strobe"); // R2

  AST_NO_VALID_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !frameStb |=> !frameValid) else $error("valid without strobe"); // R2

  AST_HDR_TRACKS_DV: assert property (@(posedge clk) disable iff (!rstN)
    frameStb |=> frameOut[119:116] == ($past(dataValid) ? 4'b0101 : 4'b0110))
    else $error("header does not follow dataValid"); // R3

  AST_RAW_PASS: assert property (@(posedge clk) disable iff (!rstN)
    (frameStb && mode == 2'd2) |=> frameOut[115:0] == $past({scBits, userData, wideData}))
    else $error("raw frame altered"); // R7

endmodule

// File: tb/sim_fb_frame_builder.sv
module sim_fb_frame_builder;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG_CYCLES = 200000;

  logic         clk = 1'b0;
  logic         rstN;
  logic         frameStb;
  logic         dataValid;
  logic [1:0]   mode;
  logic [79:0]  userData;
  logic [3:0]   scBits;
  logic [31:0]  wideData;
  logic [119:0] frameOut;
  logic         frameValid;

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  logic [57:0]  mh;      // bit 0 = most recent payload scrambled bit
  logic [30:0]  wh;      // bit 0 = most recent wide scrambled bit
  logic [119:0] lastExp;
  logic [3:0]   expT[15];
  int           logT[16];

  always #(CLK_PERIOD/2) clk = ~clk;

  fb_frame_builder u0 (
    .clk(clk), .rstN(rstN), .frameStb(frameStb), .dataValid(dataValid), .mode(mode),
    .userData(userData), .scBits(scBits), .wideData(wideData),
    .frameOut(frameOut), .frameValid(frameValid)
  );

  task automatic chk(input bit ok, input string req, input logic [119:0] act, input logic [119:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [83:0] scrMain(input logic [83:0] d);
    logic [83:0] o;
    for (int i = 0; i < 84; i++) begin
      o[i] = d[i] ^ mh[38] ^ mh[57];
      mh = {mh[56:0], o[i]};
    end
    return o;
  endfunction

  function automatic logic [31:0] scrWide(input logic [31:0] d);
    logic [31:0] o;
    for (int i = 0; i < 32; i++) begin
      o[i] = d[i] ^ wh[27] ^ wh[30];
      wh = {wh[29:0], o[i]};
    end
    return o;
  endfunction

  function automatic logic [3:0] tmul(input logic [3:0] a, input logic [3:0] b);
    if (a == 0 || b == 0) return 4'h0;
    return expT[(logT[a] + logT[b]) % 15];
  endfunction

  // codeword evaluated at alpha^1..alpha^4 must vanish
  function automatic bit synOk(input logic [119:0] f, input int code);
    logic [3:0] s;
    for (int k = 1; k <= 4; k++) begin
      s = 4'h0;
      for (int t = 0; t < 15; t++) s = s ^ tmul(f[8*t + 4*code +: 4], expT[(k*t) % 15]);
      if (s != 4'h0) return 0;
    end
    return 1;
  endfunction

  // called at a negedge; checks at the following negedge
  task automatic cycle(input bit stb, input bit dv, input logic [1:0] md,
                       input logic [79:0] ud, input logic [3:0] sc, input logic [31:0] wd);
    logic [119:0] e;
    logic [83:0]  pay;
    frameStb = stb; dataValid = dv; mode = md; userData = ud; scBits = sc; wideData = wd;
    e = lastExp;
    if (stb) begin
      e[119:116] = dv ? 4'b0101 : 4'b0110;
      if (md == 2'd2) begin
        e[115:0] = {sc, ud, wd};
      end else begin
        pay = scrMain({sc, ud});
        e[115:32] = pay;
        if (md == 2'd1) e[31:0] = scrWide(wd);
      end
    end
    @(negedge clk);
    if (stb) begin
      chk(frameValid == 1'b1, "R2 valid pulse", {119'b0, frameValid}, 120'd1);
      chk(frameOut[119:116] == e[119:116], "R3 header", frameOut, e);
      case (md)
        2'd0: begin
          chk(frameOut[119:32] == e[119:32], "R4 payload scrambling", frameOut, e);
          chk(synOk(frameOut, 0) && synOk(frameOut, 1), "R5 parity roots", frameOut, e);
          e[31:0] = frameOut[31:0];
        end
        2'd3: begin
          chk(frameOut[119:32] == e[119:32], "R9 alt mode payload", frameOut, e);
          chk(synOk(frameOut, 0) && synOk(frameOut, 1), "R9 alt mode parity", frameOut, e);
          e[31:0] = frameOut[31:0];
        end
        2'd1: chk(frameOut == e, "R6 wide frame", frameOut, e);
        default: chk(frameOut == e, "R7 raw frame", frameOut, e);
      endcase
    end else begin
      chk(frameValid == 1'b0, "R2 no valid in gap", {119'b0, frameValid}, 120'd0);
      chk(frameOut == e, "R2 hold in gap", frameOut, e);
    end
    lastExp = e;
  endtask

  initial begin
    #(CLK_PERIOD * WATCHDOG_CYCLES);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [4:0] e5;
    logic [3:0] ev;
    ev = 4'h1;
    for (int i = 0; i < 15; i++) begin
      expT[i] = ev;
      logT[ev] = i;
      e5 = {ev, 1'b0};
      if (e5[4]) e5 = e5 ^ 5'h13;
      ev = e5[3:0];
    end
    logT[0] = 0;
    void'($urandom(32'd1234));
    mh = '1; wh = '1; lastExp = '0;
    rstN = 1'b0; frameStb = 0; dataValid = 1; mode = 0; userData = '1; scBits = '1; wideData = '1;
    repeat (3) @(negedge clk);
    chk(frameOut == 120'd0, "R1 frame zero in reset", frameOut, 120'd0);
    chk(frameValid == 1'b0, "R1 valid low in reset", {119'b0, frameValid}, 120'd0);
    rstN = 1'b1;
    @(negedge clk);
    // directed corners
    cycle(1, 1, 2'd0, '0, 4'h0, '0);                        // R4 seed/feedback only
    cycle(0, 1, 2'd0, '1, 4'hF, '1);                        // R2 gap
    cycle(1, 0, 2'd0, '1, 4'hF, '0);                        // R3 idle header
    cycle(1, 1, 2'd2, 80'h0123456789ABCDEF0011, 4'hA, 32'hDEADBEEF); // R7
    cycle(1, 1, 2'd1, '0, 4'h0, '0);                        // R6 wide seed
    cycle(1, 1, 2'd2, '1, 4'h5, 32'h0);                     // R7 no advance
    cycle(1, 1, 2'd1, 80'h5, 4'h3, 32'h80000001);           // R8 wide history intact
    cycle(1, 1, 2'd3, 80'hFFFF0000FFFF0000FFFF, 4'hC, '0);  // R9
    cycle(1, 1, 2'd0, '0, 4'h0, '0);                        // R8 main after wide
    for (int n = 0; n < 3000; n++) begin
      logic [79:0] ud;
      ud = {$urandom, $urandom, $urandom};
      cycle(($urandom % 4) != 0, ($urandom % 3) != 0, 2'($urandom), ud, 4'($urandom), $urandom);
    end
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule